// File: doc/BRIEF.md
# Four-Point Inverse DCT Datapath

This block computes the one-dimensional four-point inverse discrete cosine transform used by block-based video decoders. It takes four signed 16-bit coefficients in one cycle and returns four signed 16-bit spatial samples one clock later. A larger decoder would call it once per row and once per column of a 4x4 tile. Transposition, two-dimensional sequencing and pixel reconstruction belong to the surrounding logic and are not part of this block.

Inside, the datapath has two halves that run in parallel. The even half forms the wrapped 16-bit sum and difference of coefficients 0 and 2, then scales each by cos(pi/4) in 14-bit fixed point. The odd half forms two rotations of coefficients 1 and 3 by cos(pi/8) and cos(3pi/8) at full 32-bit precision. Each of the four products is rounded by a saturating shift right of 14. A final butterfly of wrapping 16-bit adds and subtracts combines the two halves, and a single register stage holds the result. There is no control state: a lane register loads whenever the input is valid, and otherwise it holds its value.

Top module: `idct4_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` goes to 0 after that edge and all four output lanes go to 0.
- R2: `out_valid` after each rising edge equals `in_valid` sampled at that edge, so the latency is exactly one clock.
- R3: When `in_valid` is 0 at an edge, all four output lanes keep their previous values, whatever the input lanes carry.
- R4: The even terms use s = (c0 + c2) and d = (c0 - c2), each truncated to 16 bits in two's complement before being multiplied by 11585.
- R5: The odd terms are p = c1*6270 - c3*15137 and q = c1*15137 + c3*6270, computed without loss in 32 bits.
- R6: Each of the four products v is reduced to floor((v + 8192) / 16384) and then clamped to the range -32768 to 32767.
- R7: With the rounded values E0 = rnd(s*11585), E1 = rnd(d*11585), P = rnd(p) and Q = rnd(q), the outputs are y0 = E0+Q, y1 = E1+P, y2 = E1-P and y3 = E0-Q, each truncated to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input lanes carry a coefficient set |
| in_c0 | input | 16 | Signed coefficient 0 (DC) |
| in_c1 | input | 16 | Signed coefficient 1 |
| in_c2 | input | 16 | Signed coefficient 2 |
| in_c3 | input | 16 | Signed coefficient 3 |
| out_valid | output | 1 | Output lanes carry a new result |
| out_y0 | output | 16 | Signed sample 0 |
| out_y1 | output | 16 | Signed sample 1 |
| out_y2 | output | 16 | Signed sample 2 |
| out_y3 | output | 16 | Signed sample 3 |

## Verification
The only internal state is the set of output registers and the valid flag. A wrong value in either shows at the ports in the cycle after the edge that loaded it. A slip in rounding, saturation or wrap shows up as a wrong sample on particular lanes for particular input patterns. So the bench sweeps each lane over a set of values that includes both extremes, the values next to zero and the points where rounding changes. It compares every result, one clock after the input, against an integer model. It also checks the hold behaviour and the reset behaviour at the ports in the cycle just after the stimulus.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
    // data and coefficient lane width
    localparam int LANE_W = 16;
    // fractional bits of the fixed-point constants
    localparam int FRAC_W = 14;
    // cos(pi/4), cos(pi/8), cos(3pi/8) scaled by 2^14
    localparam int K_QUARTER = 11585;
    localparam int K_EIGHTH  = 15137;
    localparam int K_3EIGHTH = 6270;
endpackage

// File: rtl/idct4_rndsat.sv
module idct4_rndsat #(
    parameter int DW   = 16,
    parameter int PW   = 32,
    parameter int FRAC = 14
) (
    input  logic signed [PW-1:0] prod,
    output logic signed [DW-1:0] rnd
);
    localparam logic signed [PW:0] HALF =
        {{(PW-FRAC+1){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [PW:0] QMAX =
        {{(PW-DW+2){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW:0] QMIN =
        {{(PW-DW+2){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] LMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] LMIN = {1'b1, {(DW-1){1'b0}}};

    logic signed [PW:0] wide;
    logic signed [PW:0] shifted;

    assign wide    = {prod[PW-1], prod} + HALF;
    assign shifted = wide >>> FRAC;

    always_comb begin
        if (shifted > QMAX) begin
            rnd = LMAX;
        end else if (shifted < QMIN) begin
            rnd = LMIN;
        end else begin
            rnd = shifted[DW-1:0];
        end
    end

    always_comb begin
        if (!prod[PW-1]) begin
            // R6
            sign_pos_chk: assert (!rnd[DW-1]);
        end
        if (prod[PW-1]) begin
            // R6
            sign_neg_chk: assert (rnd[DW-1] || (rnd == '0));
        end
    end
endmodule

// File: rtl/idct4_even.sv
module idct4_even #(
    parameter int DW   = 16,
    parameter int FRAC = 14,
    parameter int KQ   = 11585
) (
    input  logic signed [DW-1:0] c_a,
    input  logic signed [DW-1:0] c_b,
    output logic signed [DW-1:0] e_sum,
    output logic signed [DW-1:0] e_dif
);
    localparam int PW = 2 * DW;
    localparam logic signed [DW-1:0] KQ_L = DW'(KQ);

    logic signed [DW-1:0] sum_w;
    logic signed [DW-1:0] dif_w;
    logic signed [PW-1:0] p_sum;
    logic signed [PW-1:0] p_dif;

    // both wrap at lane width before scaling
    assign sum_w = c_a + c_b;
    assign dif_w = c_a - c_b;
    assign p_sum = PW'(sum_w) * PW'(KQ_L);
    assign p_dif = PW'(dif_w) * PW'(KQ_L);

    idct4_rndsat #(.DW(DW), .PW(PW), .FRAC(FRAC)) u_rs_sum (
        .prod (p_sum),
        .rnd  (e_sum)
    );
    idct4_rndsat #(.DW(DW), .PW(PW), .FRAC(FRAC)) u_rs_dif (
        .prod (p_dif),
        .rnd  (e_dif)
    );
endmodule

// File: rtl/idct4_odd.sv
module idct4_odd #(
    parameter int DW   = 16,
    parameter int FRAC = 14,
    parameter int KA   = 15137,
    parameter int KB   = 6270
) (
    input  logic signed [DW-1:0] c_a,
    input  logic signed [DW-1:0] c_b,
    output logic signed [DW-1:0] o_lo,
    output logic signed [DW-1:0] o_hi
);
    localparam int PW = 2 * DW;
    localparam logic signed [PW-1:0] KA_L = PW'(KA);
    localparam logic signed [PW-1:0] KB_L = PW'(KB);

    logic signed [PW-1:0] a_w;
    logic signed [PW-1:0] b_w;
    logic signed [PW-1:0] p_lo;
    logic signed [PW-1:0] p_hi;

    assign a_w  = PW'(c_a);
    assign b_w  = PW'(c_b);
    assign p_lo = (a_w * KB_L) - (b_w * KA_L);
    assign p_hi = (a_w * KA_L) + (b_w * KB_L);

    idct4_rndsat #(.DW(DW), .PW(PW), .FRAC(FRAC)) u_rs_lo (
        .prod (p_lo),
        .rnd  (o_lo)
    );
    idct4_rndsat #(.DW(DW), .PW(PW), .FRAC(FRAC)) u_rs_hi (
        .prod (p_hi),
        .rnd  (o_hi)
    );
endmodule

// File: rtl/idct4_core.sv
module idct4_core
    import idct4_pkg::*;
#(
    parameter int DW   = LANE_W,
    parameter int FRAC = FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_c0,
    input  logic signed [DW-1:0] in_c1,
    input  logic signed [DW-1:0] in_c2,
    input  logic signed [DW-1:0] in_c3,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_y0,
    output logic signed [DW-1:0] out_y1,
    output logic signed [DW-1:0] out_y2,
    output logic signed [DW-1:0] out_y3
);
    localparam int LANES = 4;

    logic [1:0][DW-1:0]       ev;
    logic [1:0][DW-1:0]       od;
    logic [LANES-1:0][DW-1:0] y_n;
    logic [LANES-1:0][DW-1:0] y_q;
    logic                     v_q;

    idct4_even #(.DW(DW), .FRAC(FRAC), .KQ(K_QUARTER)) u_even (
        .c_a   (in_c0),
        .c_b   (in_c2),
        .e_sum (ev[0]),
        .e_dif (ev[1])
    );

    idct4_odd #(.DW(DW), .FRAC(FRAC), .KA(K_EIGHTH), .KB(K_3EIGHTH)) u_odd (
        .c_a  (in_c1),
        .c_b  (in_c3),
        .o_lo (od[0]),
        .o_hi (od[1])
    );

    // output butterfly: lanes 0/3 pair even0 with odd1, lanes 1/2 pair even1 with odd0
    for (genvar i = 0; i < LANES; i++) begin : g_bfly
        localparam int  EI  = (i == 0 || i == LANES - 1) ? 0 : 1;
        localparam int  OI  = 1 - EI;
        localparam bit  SUB = (i >= LANES / 2);
        if (SUB) begin : g_sub
            assign y_n[i] = ev[EI] - od[OI];
        end else begin : g_add
            assign y_n[i] = ev[EI] + od[OI];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            y_q <= '0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                y_q <= y_n;
            end
        end
    end

    assign out_valid = v_q;
    assign out_y0    = y_q[0];
    assign out_y1    = y_q[1];
    assign out_y2    = y_q[2];
    assign out_y3    = y_q[3];

    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_y0 == '0));
    // R2
    valid_up_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
    // R2
    valid_dn_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
    // R3
    hold_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_y0) && $stable(out_y1) && $stable(out_y2) && $stable(out_y3)));
endmodule

// File: tb/idct4_core_test.sv
module idct4_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] c0 = '0, c1 = '0, c2 = '0, c3 = '0;
    logic        out_valid;
    logic [15:0] y0, y1, y2, y3;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    idct4_core uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_c0     (c0),
        .in_c1     (c1),
        .in_c2     (c2),
        .in_c3     (c3),
        .out_valid (out_valid),
        .out_y0    (y0),
        .out_y1    (y1),
        .out_y2    (y2),
        .out_y3    (y3)
    );

    function automatic int rs(longint v);
        longint t;
        t = (v + 64'sd8192) >>> 14;
        if (t > 32767) return 32767;
        if (t < -32768) return -32768;
        return int'(t);
    endfunction

    function automatic int wrap16(int v);
        logic [15:0] t;
        t = v[15:0];
        return int'($signed(t));
    endfunction

    function automatic logic [63:0] model(int x0, int x1, int x2, int x3);
        int s, d, e0, e1, p, q;
        s  = wrap16(x0 + x2);
        d  = wrap16(x0 - x2);
        e0 = rs(longint'(s) * 11585);
        e1 = rs(longint'(d) * 11585);
        p  = rs(longint'(x1) * 6270 - longint'(x3) * 15137);
        q  = rs(longint'(x1) * 15137 + longint'(x3) * 6270);
        return {16'(e0 - q), 16'(e1 - p), 16'(e1 + p), 16'(e0 + q)};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
        end
    endtask

    task automatic apply(int x0, int x1, int x2, int x3, string tag);
        logic [63:0] e;
        @(negedge clk);
        in_valid = 1'b1;
        c0 = 16'(x0); c1 = 16'(x1); c2 = 16'(x2); c3 = 16'(x3);
        e = model(x0, x1, x2, x3);
        @(negedge clk);
        chk({tag, " valid"}, {15'd0, out_valid}, 16'd1);
        chk({tag, " y0"}, y0, e[15:0]);
        chk({tag, " y1"}, y1, e[31:16]);
        chk({tag, " y2"}, y2, e[47:32]);
        chk({tag, " y3"}, y3, e[63:48]);
    endtask

    int vals[12] = '{-32768, -32767, -16384, -8192, -2, -1, 0, 1, 2, 8191, 16384, 32767};

    initial begin
        logic [15:0] h0, h1, h2, h3;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {15'd0, out_valid}, 16'd0);
        chk("R1 y0", y0, 16'd0);
        chk("R1 y3", y3, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        // R2 idle after reset
        chk("R2 idle", {15'd0, out_valid}, 16'd0);

        // R4 sum wraps: 32767+1 becomes -32768 before scaling
        apply(32767, 0, 1, 0, "R4");
        chk("R4 y0 wrapped", y0, 16'(-23170));
        // R5 odd rotation
        apply(0, 1000, 0, -2000, "R5");
        // R6 saturation of odd term
        apply(0, 32767, 0, 32767, "R6");
        chk("R6 y0 saturated", y0, 16'd32767);
        chk("R6 y3 saturated", y3, 16'(-32767));
        apply(-32768, -32768, -32768, -32768, "R6 min");

        // R3 hold with changing inputs
        h0 = y0; h1 = y1; h2 = y2; h3 = y3;
        @(negedge clk);
        in_valid = 1'b0;
        c0 = 16'd1234; c1 = 16'd77; c2 = 16'(-5); c3 = 16'd999;
        @(negedge clk);
        chk("R2 drop", {15'd0, out_valid}, 16'd0);
        chk("R3 y0", y0, h0);
        chk("R3 y1", y1, h1);
        chk("R3 y2", y2, h2);
        chk("R3 y3", y3, h3);

        // R7 sweep over all lane combinations
        foreach (vals[a]) foreach (vals[b]) foreach (vals[c]) foreach (vals[d])
            apply(vals[a], vals[b], vals[c], vals[d], "R7 sweep");

        // R1 reset mid-stream
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R1 mid valid", {15'd0, out_valid}, 16'd0);
        chk("R1 mid y1", y1, 16'd0);
        rst = 1'b0;
        in_valid = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule